// File: doc/BRIEF.md
# Output Driver Startup Configuration Sequencer

This block is a small SPI master that walks a multi-channel output driver from power-up to its operating state. After a start pulse it sends a software reset frame and waits a programmable settle time. It then unlocks the configuration registers. Next it reads a list of four mapped output numbers and sends one input-mapping frame for each entry. It writes the output-enable and direct-drive mask registers and ends with a frame that turns the outputs on globally.

The output-enable and direct-drive masks start from a fixed preset: the low nibbles of mask bytes 0 and 3 are set. The sequencer adds one bit per mapped output while it runs. It checks each entry before that entry's frame is sent. A number below 5, or one whose bit is already set, stops the sequence before any mask register is written, and the block flags an error. A new start pulse at any time drops the frame in progress and runs the whole sequence again, using the map captured at that pulse.

Top module: `cfg_startup_seq`

## Requirements
- R1: While rst_n is low and after its release, cs_n is 1, sclk is 0, and done and err are 0 until a start pulse.
- R2: Every frame is 16 bits, sent LSB first. It is shifted out on mosi and sampled by the device on the rising sclk edge. Bit 0 is 1 (write), bits 7:1 hold the 7-bit address, and bits 15:8 hold the data. cs_n stays low for exactly 16 rising sclk edges, and sclk is low whenever cs_n is high.
- R3: The first frame is address 0x1A, data 0x03. cs_n then stays high for at least WAIT_CYC clock cycles before the next frame.
- R4: The second frame is address 0x1E, data 0x01.
- R5: For each map entry N, taken in list order (entry k at map_cfg bits 5k+4:5k), one frame is sent to address 0x53 + (N-1)/8 with data N-5.
- R6: Mask byte i starts as 0x0F for i = 0 and i = 3, and as 0x00 otherwise. Each accepted entry N adds bit (N-1) mod 8 to byte (N-1)/8.
- R7: After the map frames, for i = 0, 1, 2, 3 in ascending order, the block sends mask byte i to address 0x5B+i and then to address 0x57+i.
- R8: The last frame is address 0x1C, data 0x02. done then goes to 1 with err at 0, and both stay that way with no further frames until the next start.
- R9: If an entry N is below 5, no frame is sent for it or after it. done and err both go to 1.
- R10: If the bit of an entry is already set, by an earlier entry or by the preset (N = 1..4 or 25..28), the block behaves as in R9.
- R11: A start pulse at any time raises cs_n in the next cycle, clears done and err, and restarts the sequence from the reset frame with map_cfg as it was during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts or restarts the sequence |
| map_cfg | input | 20 | Four 5-bit mapped output numbers, entry k at bits 5k+4:5k |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the device |
| cs_n | output | 1 | SPI chip select, active low |
| done | output | 1 | Sequence finished, successfully or with an error |
| err | output | 1 | Sequence stopped on an illegal or duplicate mapping |

## Verification
The bench builds the block with DIV_HALF = 2 and WAIT_CYC = 50. With these values a full fifteen-frame run takes about a thousand cycles, so dozens of random and directed maps fit in the cycle budget. The short settle time still leaves a gap large enough to measure, so a shortened wait would show up in the results. Covered cases include data 0 at N = 5, the top byte at N = 31, collisions with the preset at N = 25..28, repeated entries, and a restart mid-frame with a different map.

// File: rtl/cfg_seq_pkg.sv
// Shared types and constants for the startup configuration sequencer.
// Assumes a device with 7-bit register addresses and 8-bit data.
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_WAIT,
        ST_UNLOCK,
        ST_MAP,
        ST_MASK,
        ST_ENABLE,
        ST_DONE,
        ST_ERR
    } seq_state_t;

    localparam logic [6:0] A_SWRESET = 7'h1A;
    localparam logic [7:0] D_SWRESET = 8'h03;
    localparam logic [6:0] A_LOCK    = 7'h1E;
    localparam logic [7:0] D_UNLOCK  = 8'h01;
    localparam logic [6:0] A_GLOBEN  = 7'h1C;
    localparam logic [7:0] D_GLOBEN  = 8'h02;
    localparam logic [6:0] A_INMAP   = 7'h53;
    localparam logic [6:0] A_DDRIVE  = 7'h57;
    localparam logic [6:0] A_OUTEN   = 7'h5B;

    // Packs a write frame: write flag in bit 0, address above it, data on top.
    function automatic logic [15:0] make_frame(logic [6:0] addr, logic [7:0] data);
        return {data, addr, 1'b1};
    endfunction

endpackage

// File: rtl/cfg_spi_tx.sv
// Single-frame SPI transmitter.
// Sends one FRAME_W-bit word LSB first with cs_n low for the whole frame.
// sclk idles low; mosi changes while sclk is low and is sampled on the rising edge.
// Assumes go is only raised while busy is low; clr drops any frame at once.
module cfg_spi_tx #(
    parameter int DIV_HALF = 4,
    parameter int FRAME_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [DIV_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;

    // Shift engine: half-period timing, bit counting and frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            shreg   <= '0;
            div_cnt <= '0;
            bit_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy    <= 1'b1;
                    cs_n    <= 1'b0;
                    shreg   <= frame;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_W'(DIV_HALF - 1)) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= shreg >> 1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // Data line: current LSB while a frame is open, low otherwise.
    assign mosi = busy & shreg[0];

    // R2: the clock never toggles outside an open frame.
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: a new frame is requested only when the shifter is free.
    p_go_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !clr) |-> !busy);

    // R2: a frame closes normally only after its last bit.
    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(clr)) |-> ($past(bit_cnt) == BIT_W'(FRAME_W - 1)));

endmodule

// File: rtl/cfg_wait_timer.sv
// Settle-time down-counter.
// load arms it with WAIT_CYC; zero is high once the count has run out.
module cfg_wait_timer #(
    parameter int WAIT_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(WAIT_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/cfg_startup_seq.sv
// Startup configuration sequencer for a multi-channel output driver.
// Order: reset frame, settle wait, unlock, one map frame per entry,
// output-enable/direct-drive mask pairs, global enable.
// Entries are checked before their frame; a bad entry stops the run.
// Assumes that start is a single-cycle pulse; map_cfg is sampled only then.
module cfg_startup_seq
    import cfg_seq_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int WAIT_CYC = 300000,
    parameter int MAP_CNT  = 4,
    parameter int NUM_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [MAP_CNT*NUM_W-1:0] map_cfg,
    output logic                     sclk,
    output logic                     mosi,
    output logic                     cs_n,
    output logic                     done,
    output logic                     err
);
    localparam int MASK_BYTES = 4;
    localparam int MASK_W     = 8 * MASK_BYTES;
    localparam int IDX_W      = $clog2(2 * MASK_BYTES);
    localparam logic [MASK_W-1:0] MASK_PRESET = 32'h0F00_000F;
    localparam logic [NUM_W-1:0]  MIN_NUM     = NUM_W'(5);

    seq_state_t                 state;
    logic                       issued;
    logic [IDX_W-1:0]           idx;
    logic [MASK_W-1:0]          mask;
    logic [MAP_CNT*NUM_W-1:0]   map_q;

    logic        tx_go, tx_busy, tx_done, wait_zero, wait_load;
    logic [15:0] tx_frame;
    logic [NUM_W-1:0] cur_num, num_m1;
    logic        entry_bad;
    logic [1:0]  byte_sel;
    logic [7:0]  mask_byte;

    // Current map entry, its bit position and its legality.
    always_comb begin
        cur_num   = map_q[int'(idx[1:0]) * NUM_W +: NUM_W];
        num_m1    = cur_num - 1'b1;
        entry_bad = (cur_num < MIN_NUM) || mask[num_m1];
        byte_sel  = idx[2:1];
        mask_byte = mask[int'(byte_sel) * 8 +: 8];
    end

    // Frame contents for the state now being served.
    always_comb begin
        case (state)
            ST_RESET:  tx_frame = make_frame(A_SWRESET, D_SWRESET);
            ST_UNLOCK: tx_frame = make_frame(A_LOCK, D_UNLOCK);
            ST_MAP:    tx_frame = make_frame(A_INMAP + 7'(num_m1 >> 3),
                                             8'(cur_num - MIN_NUM));
            ST_MASK:   tx_frame = make_frame((idx[0] ? A_DDRIVE : A_OUTEN) + 7'(byte_sel),
                                             mask_byte);
            ST_ENABLE: tx_frame = make_frame(A_GLOBEN, D_GLOBEN);
            default:   tx_frame = '0;
        endcase
    end

    // Request a frame once per sending state, unless the entry is rejected.
    always_comb begin
        tx_go = !issued && ((state == ST_RESET) || (state == ST_UNLOCK) ||
                            (state == ST_MASK) || (state == ST_ENABLE) ||
                            ((state == ST_MAP) && !entry_bad));
    end

    assign wait_load = (state == ST_RESET) && tx_done;

    // Step through the startup order and grow the mask as entries are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            issued <= 1'b0;
            idx    <= '0;
            mask   <= MASK_PRESET;
            map_q  <= '0;
        end else if (start) begin
            state  <= ST_RESET;
            issued <= 1'b0;
            idx    <= '0;
            mask   <= MASK_PRESET;
            map_q  <= map_cfg;
        end else begin
            if (tx_go) issued <= 1'b1;
            case (state)
                ST_RESET: if (tx_done) begin
                    issued <= 1'b0;
                    state  <= ST_WAIT;
                end
                ST_WAIT: if (wait_zero) state <= ST_UNLOCK;
                ST_UNLOCK: if (tx_done) begin
                    issued <= 1'b0;
                    state  <= ST_MAP;
                end
                ST_MAP: begin
                    if (!issued && entry_bad) begin
                        state <= ST_ERR;
                    end else if (!issued) begin
                        mask[num_m1] <= 1'b1;
                    end
                    if (tx_done) begin
                        issued <= 1'b0;
                        if (idx == IDX_W'(MAP_CNT - 1)) begin
                            idx   <= '0;
                            state <= ST_MASK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_MASK: if (tx_done) begin
                    issued <= 1'b0;
                    if (idx == IDX_W'(2 * MASK_BYTES - 1)) begin
                        idx   <= '0;
                        state <= ST_ENABLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ENABLE: if (tx_done) begin
                    issued <= 1'b0;
                    state  <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assign done = (state == ST_DONE) || (state == ST_ERR);
    assign err  = (state == ST_ERR);

    cfg_spi_tx #(
        .DIV_HALF (DIV_HALF),
        .FRAME_W  (16)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .go    (tx_go),
        .frame (tx_frame),
        .busy  (tx_busy),
        .done  (tx_done),
        .sclk  (sclk),
        .mosi  (mosi),
        .cs_n  (cs_n)
    );

    cfg_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .load  (wait_load),
        .zero  (wait_zero)
    );

    // R3: no frame is open during the settle wait.
    p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cs_n && !tx_busy));

    // R9: an error is always reported together with completion.
    p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8: completion holds until the next start.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R11: a start pulse closes any open frame on the next cycle.
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cs_n && !done));

endmodule

// File: tb/cfg_startup_seq_tb.sv
// Bench: random and directed maps, with frames decoded by a bench-side SPI monitor.
module cfg_startup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;
    localparam int WAIT_CYC   = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] map_cfg = '0;
    logic        sclk, mosi, cs_n, done, err;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_startup_seq #(
        .DIV_HALF (DIV_HALF),
        .WAIT_CYC (WAIT_CYC)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .map_cfg (map_cfg),
        .sclk    (sclk),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .done    (done),
        .err     (err)
    );

    // Bench-side SPI monitor.
    longint      cyc = 0;
    logic [15:0] sh = '0;
    int          nb = 0;
    logic [15:0] got [0:31];
    int          gbits [0:31];
    int          ngot = 0;
    longint      t_rise1 = 0, t_fall2 = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge sclk) if (!cs_n) begin sh = {mosi, sh[15:1]}; nb++; end
    always @(negedge cs_n) begin nb = 0; if (ngot == 1) t_fall2 = cyc; end
    always @(posedge cs_n) if (rst_n && ngot < 32) begin
        got[ngot] = sh; gbits[ngot] = nb;
        if (ngot == 0) t_rise1 = cyc;
        ngot++;
    end

    // Expected frame list.
    logic [15:0] exp_f [0:31];
    int          nexp;
    bit          exp_err;

    function automatic logic [15:0] frm(int a, int d);
        return {8'(d), 7'(a), 1'b1};
    endfunction

    task automatic build_expect(logic [19:0] m);
        logic [31:0] mk = 32'h0F00_000F;
        nexp = 0; exp_err = 0;
        exp_f[nexp++] = frm(8'h1A, 8'h03);
        exp_f[nexp++] = frm(8'h1E, 8'h01);
        for (int k = 0; k < 4; k++) begin
            int n = int'(m[k*5 +: 5]);
            if (n < 5 || mk[n-1]) begin exp_err = 1; return; end
            mk[n-1] = 1'b1;
            exp_f[nexp++] = frm(8'h53 + (n-1)/8, n-5);
        end
        for (int i = 0; i < 4; i++) begin
            exp_f[nexp++] = frm(8'h5B + i, int'(mk[i*8 +: 8]));
            exp_f[nexp++] = frm(8'h57 + i, int'(mk[i*8 +: 8]));
        end
        exp_f[nexp++] = frm(8'h1C, 8'h02);
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(int i);
        if (i == 0) return "R3";
        if (i == 1) return "R4";
        if (i == nexp - 1 && !exp_err) return "R8";
        if (i < 6) return "R5";
        return "R7";
    endfunction

    task automatic pulse_start(logic [19:0] m);
        @(negedge clk); map_cfg = m; start = 1'b1;
        @(negedge clk); start = 1'b0; map_cfg = ~m;  // R11: later changes ignored
        ngot = 0; t_rise1 = 0; t_fall2 = 0;
    endtask

    task automatic run_case(logic [19:0] m);
        int w = 0;
        build_expect(m);
        pulse_start(m);
        while (!done && w < 30000) begin @(negedge clk); w++; end
        chk(done === 1'b1, "R8", "done reached", done, 1);
        repeat (40) @(negedge clk);
        chk(done === 1'b1, "R8", "done held", done, 1);
        chk(err === exp_err, exp_err ? "R9" : "R8", "err flag", err, exp_err);
        chk(ngot == nexp, exp_err ? "R10" : "R6", "frame count", ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++) begin
            chk(got[i] == exp_f[i], req_of(i), $sformatf("frame %0d", i), got[i], exp_f[i]);
            chk(gbits[i] == 16, "R2", $sformatf("frame %0d edges", i), gbits[i], 16);
        end
        if (ngot >= 2)
            chk(t_fall2 - t_rise1 >= WAIT_CYC, "R3", "settle gap", t_fall2 - t_rise1, WAIT_CYC);
    endtask

    function automatic logic [19:0] pack4(int a, int b, int c, int d);
        return {5'(d), 5'(c), 5'(b), 5'(a)};
    endfunction

    bit finished = 0;

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0 && err === 1'b0,
            "R1", "state in reset", {cs_n, sclk, done, err}, 4'b1000);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0 && err === 1'b0,
            "R1", "idle after reset", {cs_n, sclk, done, err}, 4'b1000);

        run_case(pack4(9, 10, 11, 12));     // R5 R6 R7 typical map
        run_case(pack4(5, 31, 8, 17));      // R5 boundaries: data 0, top byte
        run_case(pack4(9, 4, 11, 12));      // R9 below 5 at entry 1
        run_case(pack4(3, 9, 10, 11));      // R9 at first entry
        run_case(pack4(9, 10, 9, 12));      // R10 duplicate entry
        run_case(pack4(6, 7, 26, 12));      // R10 collides with preset byte 3
        run_case(pack4(21, 22, 23, 24));    // R6 byte 2 fill

        // R11: restart mid-frame with a different map.
        pulse_start(pack4(9, 10, 11, 12));
        while (ngot < 3) @(negedge clk);
        repeat (7) @(negedge clk);
        run_case(pack4(13, 14, 29, 30));

        for (int r = 0; r < 30; r++) begin
            int v [4];
            for (int k = 0; k < 4; k++)
                v[k] = ($urandom % 10 == 0) ? int'($urandom % 5) : 5 + int'($urandom % 27);
            run_case(pack4(v[0], v[1], v[2], v[3]));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R8", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule